// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Purge

This block is a small fully associative translation cache that sits in front of a page-table walker. It maps virtual page numbers to physical frame numbers for 32-bit virtual addresses and 36-bit physical addresses. Every entry carries the identifier of the process that owns it. Entries from many processes can therefore stay resident across a context switch, and a lookup only matches entries whose identifier equals the current process identifier.

An entry maps either a 4 KiB page or a 2 MiB superpage. A superpage entry compares fewer upper address bits and passes the low virtual bits straight through to the physical address. After a miss, external logic walks the page tables and loads the result through the fill port. Two purge commands remove stale translations: one drops a single page of one process, and the other drops every entry of one process. Software uses them after a permission change, or to answer a shootdown request, without emptying the whole cache.

Each lookup produces a registered response one cycle later. The response is exactly one of hit, miss or protection fault.

Top module: `pid_tlb`

## Requirements
- R1: After a synchronous active-high reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault` are 0 and `rsp_paddr` is 0. A lookup issued afterwards reports a miss.
- R2: A lookup request in cycle n produces `rsp_valid` in cycle n+1, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. With no request, all four are 0.
- R3: A 4 KiB entry matches when it is valid, its process identifier equals `cur_pid`, and its page number equals `lk_vaddr[31:12]`. On a hit, `rsp_paddr` = {frame[23:0], `lk_vaddr[11:0]`}.
- R4: An entry whose process identifier differs from `cur_pid` never matches, even when the page number is equal. Entries of other processes remain usable after `cur_pid` changes back.
- R5: A superpage entry (size bit 1) compares only its page-number bits [19:9] with `lk_vaddr[31:21]`. On a hit, `rsp_paddr` = {frame[23:9], `lk_vaddr[20:0]`}.
- R6: A matching write (`lk_write`=1) to an entry without write permission, or a matching read to an entry without read permission, reports `rsp_fault` instead of a hit. `rsp_paddr` is 0 whenever `rsp_hit` is 0.
- R7: A purge with `purge_all`=0 invalidates every valid entry of process `purge_pid` that the page number `purge_vpn` matches under that entry's own size rule (R3/R5). All other entries stay usable.
- R8: A purge with `purge_all`=1 invalidates every entry whose process identifier equals `purge_pid`. Entries of other processes stay usable.
- R9: A fill writes the lowest-numbered invalid entry when one exists, and leaves the round-robin pointer unchanged.
- R10: When all entries are valid, a fill replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping at the entry count, after each such replacement.
- R11: A lookup issued in the same cycle as a fill or purge sees the contents from before that update. When a fill and a purge land on the same entry in one cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pid | input | 8 | Identifier of the running process, used by lookups |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Load one translation |
| fill_pid | input | 8 | Owning process of the new translation |
| fill_vpn | input | 20 | Virtual page number (bits [8:0] ignored for a superpage) |
| fill_pfn | input | 24 | Physical frame number (bits [8:0] ignored for a superpage) |
| fill_huge | input | 1 | 1 = 2 MiB superpage, 0 = 4 KiB page |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| purge_valid | input | 1 | Purge command |
| purge_all | input | 1 | 1 = drop all entries of the process, 0 = drop one page |
| purge_pid | input | 8 | Process whose entries are purged |
| purge_vpn | input | 20 | Page number for a single-page purge |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry lacks the needed permission |
| rsp_paddr | output | 36 | Translated physical address on a hit, else 0 |

## Verification
The bench builds the block with its default of 16 entries. Sixteen fills are therefore enough to make the array full, so the round-robin replacement and its pointer advance can be observed through later lookups. The bench mixes two process identifiers on the same page number, a superpage next to 4 KiB pages, read-only and write-only entries, and both purge kinds, including a page purge that lands inside a superpage. It also frees one slot of a full array to show that a free slot is preferred over the pointer.

// File: rtl/pid_tlb_pkg.sv
package pid_tlb_pkg;
  localparam int VA_W        = 32;
  localparam int PID_W       = 8;
  localparam int PAGE_SHIFT  = 12;
  localparam int HUGE_SHIFT  = 21;
  localparam int VPN_W       = VA_W - PAGE_SHIFT;
  localparam int PFN_W       = 24;
  localparam int PA_W        = PFN_W + PAGE_SHIFT;
  localparam int SUB_W       = HUGE_SHIFT - PAGE_SHIFT;

  typedef struct packed {
    logic             valid;
    logic [PID_W-1:0] pid;
    logic             huge;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             rd;
    logic             wr;
  } tlb_entry_t;

  // Page-number match under the entry's own size rule, gated by owner and valid.
  function automatic logic entry_match(tlb_entry_t e, logic [PID_W-1:0] pid,
                                       logic [VPN_W-1:0] vpn);
    logic same_page;
    if (e.huge) same_page = (e.vpn[VPN_W-1:SUB_W] == vpn[VPN_W-1:SUB_W]);
    else        same_page = (e.vpn == vpn);
    return e.valid && (e.pid == pid) && same_page;
  endfunction
endpackage

// File: rtl/pid_tlb_victim.sv
module pid_tlb_victim
  import pid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_ENTRIES-1:0] vld,
  input  logic                   fill_valid,
  output logic [IDX_W-1:0]       victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  always_comb begin
    free_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_full   = &vld;
  assign victim_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_valid && all_full) begin
      if (rr_q == IDX_W'(NUM_ENTRIES - 1)) rr_q <= '0;
      else                                 rr_q <= rr_q + 1'b1;
    end
  end

  AST_PREFER_FREE: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !all_full) |-> !vld[victim_idx]); // R9

  AST_RR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !all_full) |=> (rr_q == $past(rr_q))); // R9

  AST_RR_STEPS: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && all_full) |=> (rr_q != $past(rr_q))); // R10
endmodule

// File: rtl/pid_tlb_store.sv
module pid_tlb_store
  import pid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fill_valid,
  input  logic [IDX_W-1:0]       fill_idx,
  input  tlb_entry_t             fill_entry,
  input  logic                   purge_valid,
  input  logic                   purge_all,
  input  logic [PID_W-1:0]       purge_pid,
  input  logic [VPN_W-1:0]       purge_vpn,
  output tlb_entry_t             ent_q [NUM_ENTRIES],
  output logic [NUM_ENTRIES-1:0] vld
);
  logic [NUM_ENTRIES-1:0] purge_hit;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      vld[i] = ent_q[i].valid;
      if (purge_all) purge_hit[i] = ent_q[i].valid && (ent_q[i].pid == purge_pid);
      else           purge_hit[i] = entry_match(ent_q[i], purge_pid, purge_vpn);
    end
  end

  // Only the valid bits are reset; payload fields are plain storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i].valid <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fill_valid && (fill_idx == IDX_W'(i))) ent_q[i] <= fill_entry;
        else if (purge_valid && purge_hit[i])      ent_q[i].valid <= 1'b0;
      end
    end
  end

  // Checker state: the identifier of the most recent purge command.
  logic [PID_W-1:0]       seen_pid_q;
  logic [NUM_ENTRIES-1:0] pid_left;
  always_ff @(posedge clk) seen_pid_q <= purge_pid;
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++)
      pid_left[i] = ent_q[i].valid && (ent_q[i].pid == seen_pid_q);
  end

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> vld[$past(fill_idx)]); // R9

  AST_PURGE_PID_GONE: assert property (@(posedge clk) disable iff (rst)
    (purge_valid && purge_all && !fill_valid) |=> (pid_left == '0)); // R8

  AST_PURGE_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (purge_valid && !fill_valid) |=> ($countones(vld) <= $countones($past(vld)))); // R7
endmodule

// File: rtl/pid_tlb_lookup.sv
module pid_tlb_lookup
  import pid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  tlb_entry_t       ent [NUM_ENTRIES],
  input  logic [PID_W-1:0] cur_pid,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] sel;
  logic             any;
  tlb_entry_t       e;
  logic             perm_ok;
  logic [PA_W-1:0]  pa;

  assign vpn = lk_vaddr[VA_W-1:PAGE_SHIFT];

  // Lowest-numbered matching entry wins.
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (entry_match(ent[i], cur_pid, vpn)) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign e       = ent[sel];
  assign perm_ok = lk_write ? e.wr : e.rd;
  assign pa      = e.huge ? {e.pfn[PFN_W-1:SUB_W], lk_vaddr[HUGE_SHIFT-1:0]}
                          : {e.pfn, lk_vaddr[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any && perm_ok;
      rsp_miss  <= lk_valid && !any;
      rsp_fault <= lk_valid && any && !perm_ok;
      rsp_paddr <= (lk_valid && any && perm_ok) ? pa : '0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R2

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R2

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid); // R2

  AST_PADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0)); // R6
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
  import pid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              fill_valid,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_huge,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              purge_valid,
  input  logic              purge_all,
  input  logic [PID_W-1:0]  purge_pid,
  input  logic [VPN_W-1:0]  purge_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);
  tlb_entry_t             ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] vld;
  logic [IDX_W-1:0]       victim_idx;
  tlb_entry_t             fill_entry;

  assign fill_entry = '{valid: 1'b1, pid: fill_pid, huge: fill_huge,
                        vpn: fill_vpn, pfn: fill_pfn, rd: fill_rd, wr: fill_wr};

  pid_tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
    .clk        (clk),
    .rst        (rst),
    .vld        (vld),
    .fill_valid (fill_valid),
    .victim_idx (victim_idx)
  );

  pid_tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk         (clk),
    .rst         (rst),
    .fill_valid  (fill_valid),
    .fill_idx    (victim_idx),
    .fill_entry  (fill_entry),
    .purge_valid (purge_valid),
    .purge_all   (purge_all),
    .purge_pid   (purge_pid),
    .purge_vpn   (purge_vpn),
    .ent_q       (ent_q),
    .vld         (vld)
  );

  pid_tlb_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
    .clk       (clk),
    .rst       (rst),
    .ent       (ent_q),
    .cur_pid   (cur_pid),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_write  (lk_write),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
  );
endmodule

// File: tb/pid_tlb_bench.sv
module pid_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cur_pid = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_pid = '0;
  logic [19:0] fill_vpn = '0;
  logic [23:0] fill_pfn = '0;
  logic        fill_huge = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0;
  logic        purge_valid = 1'b0, purge_all = 1'b0;
  logic [7:0]  purge_pid = '0;
  logic [19:0] purge_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [35:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int HIT = 0, MISS = 1, FAULT = 2;
  localparam logic [7:0] PA = 8'h11, PB = 8'h22;

  typedef struct {
    int          kind;
    logic [35:0] pa;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pid_tlb u_pid_tlb (
    .clk, .rst, .cur_pid, .lk_valid, .lk_vaddr, .lk_write,
    .fill_valid, .fill_pid, .fill_vpn, .fill_pfn, .fill_huge, .fill_rd, .fill_wr,
    .purge_valid, .purge_all, .purge_pid, .purge_vpn,
    .rsp_valid, .rsp_hit, .rsp_miss, .rsp_fault, .rsp_paddr
  );

  // Monitor: pop one expectation per response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      int got;
      got = rsp_hit ? HIT : (rsp_miss ? MISS : (rsp_fault ? FAULT : -1));
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response kind=%0d expected none", got);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        if (got != x.kind || rsp_paddr != x.pa ||
            $countones({rsp_hit, rsp_miss, rsp_fault}) != 1) begin
          errors++;
          $display("FAIL %s: kind=%0d paddr=%h expected kind=%0d paddr=%h",
                   x.tag, got, rsp_paddr, x.kind, x.pa);
        end
      end
    end
  end

  // All driver tasks start and end at a falling edge.
  task automatic lookup(input logic [7:0] pid, input logic [31:0] va, input logic wr,
                        input int kind, input logic [35:0] pa, input string tag);
    exp_t x;
    x.kind = kind; x.pa = pa; x.tag = tag;
    exp_q.push_back(x);
    cur_pid = pid; lk_vaddr = va; lk_write = wr; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [7:0] pid, input logic [19:0] vpn, input logic [23:0] pfn,
                      input logic huge, input logic rd, input logic wr);
    fill_pid = pid; fill_vpn = vpn; fill_pfn = pfn;
    fill_huge = huge; fill_rd = rd; fill_wr = wr; fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic purge(input logic all, input logic [7:0] pid, input logic [19:0] vpn);
    purge_all = all; purge_pid = pid; purge_vpn = vpn; purge_valid = 1'b1;
    @(negedge clk);
    purge_valid = 1'b0;
  endtask

  task automatic wait_drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (rsp_valid || rsp_hit || rsp_miss || rsp_fault || rsp_paddr != '0) begin
      errors++;
      $display("FAIL R1: outputs after reset v=%b h=%b m=%b f=%b pa=%h expected all 0",
               rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr);
    end
    lookup(PA, 32'h0000_5123, 1'b0, MISS, '0, "R1");

    // R3: 4 KiB hit, read and write
    fill(PA, 20'h00005, 24'hABCDE, 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0000_5123, 1'b0, HIT, {24'hABCDE, 12'h123}, "R3");
    lookup(PA, 32'h0000_5FF0, 1'b1, HIT, {24'hABCDE, 12'hFF0}, "R3");
    // R4: other process, same page
    lookup(PB, 32'h0000_5123, 1'b0, MISS, '0, "R4");
    // R6: read-only entry of PB
    fill(PB, 20'h00005, 24'h000111, 1'b0, 1'b1, 1'b0);
    lookup(PB, 32'h0000_5123, 1'b0, HIT, {24'h000111, 12'h123}, "R4");
    lookup(PB, 32'h0000_5123, 1'b1, FAULT, '0, "R6");
    lookup(PA, 32'h0000_5123, 1'b1, HIT, {24'hABCDE, 12'h123}, "R4");
    // R5: superpage
    fill(PA, 20'h40200, 24'h123400, 1'b1, 1'b1, 1'b1);
    lookup(PA, 32'h402A_B678, 1'b0, HIT, 36'h1_234A_B678, "R5");
    lookup(PA, 32'h4060_0000, 1'b0, MISS, '0, "R5");
    // R6: write-only entry
    fill(PA, 20'h00077, 24'h000077, 1'b0, 1'b0, 1'b1);
    lookup(PA, 32'h0007_7010, 1'b0, FAULT, '0, "R6");
    lookup(PA, 32'h0007_7010, 1'b1, HIT, {24'h000077, 12'h010}, "R6");

    // R7: page purge, 4 KiB and inside a superpage
    purge(1'b0, PA, 20'h00005);
    lookup(PA, 32'h0000_5123, 1'b0, MISS, '0, "R7");
    lookup(PB, 32'h0000_5123, 1'b0, HIT, {24'h000111, 12'h123}, "R7");
    purge(1'b0, PA, 20'h402FF);
    lookup(PA, 32'h402A_B678, 1'b0, MISS, '0, "R7");
    // R8: purge by process
    purge(1'b1, PB, 20'h0);
    lookup(PB, 32'h0000_5123, 1'b0, MISS, '0, "R8");
    lookup(PA, 32'h0007_7010, 1'b1, HIT, {24'h000077, 12'h010}, "R8");

    // R11: lookup in the purge cycle sees old contents
    begin
      exp_t x;
      x.kind = HIT; x.pa = {24'h000077, 12'h010}; x.tag = "R11";
      exp_q.push_back(x);
      cur_pid = PA; lk_vaddr = 32'h0007_7010; lk_write = 1'b1; lk_valid = 1'b1;
      purge_all = 1'b1; purge_pid = PA; purge_valid = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0; purge_valid = 1'b0;
    end
    lookup(PA, 32'h0007_7010, 1'b1, MISS, '0, "R11");

    // R10: fill all 16 entries, then round-robin replacement
    for (int i = 0; i < 16; i++)
      fill(PA, 20'h00100 + 20'(i), 24'h000200 + 24'(i), 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0010_F004, 1'b0, HIT, {24'h00020F, 12'h004}, "R9");
    lookup(PA, 32'h0010_0004, 1'b0, HIT, {24'h000200, 12'h004}, "R9");
    fill(PA, 20'h00300, 24'h000300, 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0010_0004, 1'b0, MISS, '0, "R10");
    lookup(PA, 32'h0010_1004, 1'b0, HIT, {24'h000201, 12'h004}, "R10");
    lookup(PA, 32'h0030_0004, 1'b0, HIT, {24'h000300, 12'h004}, "R10");
    fill(PA, 20'h00301, 24'h000301, 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0010_1004, 1'b0, MISS, '0, "R10");
    lookup(PA, 32'h0010_2004, 1'b0, HIT, {24'h000202, 12'h004}, "R10");
    // R9: a freed slot is used before the pointer slot
    purge(1'b0, PA, 20'h00105);
    fill(PA, 20'h00302, 24'h000302, 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0010_2004, 1'b0, HIT, {24'h000202, 12'h004}, "R9");
    lookup(PA, 32'h0030_2004, 1'b0, HIT, {24'h000302, 12'h004}, "R9");
    lookup(PA, 32'h0010_5004, 1'b0, MISS, '0, "R9");
    // R10: next full-array fill still takes the pointer slot
    fill(PA, 20'h00303, 24'h000303, 1'b0, 1'b1, 1'b1);
    lookup(PA, 32'h0010_2004, 1'b0, MISS, '0, "R10");

    wait_drain();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing expected 0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule